// File: doc/BRIEF.md
# Motor Command Port over SPI

This block is an SPI target (clock idles low, data sampled on the rising edge, changed on the falling edge) that turns each chip-select window into one command frame. The controller's first byte selects an operation. The block's first reply byte is always a status snapshot. The rest of the frame carries a fixed payload. Depending on the command, the block returns encoder deltas and a delta-time word, hall readings, or the stored duty settings. During a write it also takes in five duty words.

The SPI pins are brought into the system clock domain through two-flop synchronizers and edge-detected. The serial clock must therefore be at least eight times slower than the system clock. Five duty registers (11-bit sign and magnitude, with the magnitude capped) drive the motor power stage. A motor-enable level and a one-cycle watchdog refresh pulse are also produced here. The encoder counters, halls and fault flags are inputs from neighbouring logic.

Top module: `motor_spi_regs`

## Requirements
- R1: The first byte shifted out in every frame is the status byte {sys_ready, wdog_tripped, motors_en, motor_fault[4:0]} (bit 7 down to bit 0), sent MSB first and sampled at chip-select assertion.
- R2: Command 0xB0 sets motors_en and 0x30 clears it, taking effect once the command byte has been received.
- R3: Command 0x80 is followed by five 16-bit duty words, each low byte first. The duty outputs take the new values only when chip select is released after all ten payload bytes. A shorter frame leaves them unchanged.
- R4: A written word is interpreted by its low 11 bits: bit 10 is the sign and bits 9:0 the magnitude. A magnitude above 511 is stored as 511, and bits 15:11 are ignored.
- R5: Commands 0x80 and 0x91 return four 16-bit encoder deltas and then the delta-time word, each high byte first.
- R6: Command 0x92 returns the five 8-bit hall values, motor 0 first.
- R7: Command 0x93 returns the five stored duties, each zero-extended to 16 bits, high byte first.
- R8: Bytes past a command's payload return 0x00, and bytes received there change nothing.
- R9: Any other command byte returns the status byte and then zeros, and changes neither the duties nor the motor enable.
- R10: Receiving command byte 0x80 produces a wdog_kick pulse exactly one clock cycle long.
- R11: A 0xB0 command produces a wdog_kick pulse when the two preceding recognised commands were 0xB0 and then 0x30. Any other recognised command breaks that sequence, and unknown commands do not affect it.
- R12: spi_miso is low while chip select is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Controller-to-block data |
| spi_miso | output | 1 | Block-to-controller data |
| sys_ready | input | 1 | Status bit 7 |
| wdog_tripped | input | 1 | Status bit 6 |
| motor_fault | input | 5 | Status bits 4:0, one per motor |
| enc_delta_flat | input | 64 | Four 16-bit encoder deltas, motor 0 in bits 15:0 |
| delta_time | input | 16 | Elapsed-time word |
| hall_flat | input | 40 | Five 8-bit hall values, motor 0 in bits 7:0 |
| duty_flat | output | 55 | Five 11-bit committed duties, motor 0 in bits 10:0 |
| motors_en | output | 1 | Motor enable level |
| wdog_kick | output | 1 | One-cycle watchdog refresh pulse |

## Verification
The duty commit at the end of a write frame and the duty readback of the next frame both act on the same registers. The bench therefore sends a 0x93 frame only four system cycles after each 0x80 frame releases chip select. It passes only if the readback shows the values just written, already saturated.

A second collision involves the enable command. The same byte both toggles motors_en and advances the refresh sequence, so the bench counts kick pulses across enable and disable runs that are broken by other commands.

// File: rtl/mspi_pkg.sv
package mspi_pkg;
  localparam logic [7:0] OP_MOTOR_OFF = 8'h30;
  localparam logic [7:0] OP_MOTOR_ON  = 8'hB0;
  localparam logic [7:0] OP_WR_DUTY   = 8'h80;
  localparam logic [7:0] OP_RD_ENC    = 8'h91;
  localparam logic [7:0] OP_RD_HALL   = 8'h92;
  localparam logic [7:0] OP_RD_DUTY   = 8'h93;

  typedef enum logic [1:0] {
    KSEQ_IDLE   = 2'd0,
    KSEQ_ON     = 2'd1,
    KSEQ_ON_OFF = 2'd2
  } kick_seq_e;
endpackage

// File: rtl/mspi_shifter.sv
module mspi_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  input  logic [7:0] tx_first,
  input  logic [7:0] tx_next,
  output logic       spi_miso,
  output logic       frame_start,
  output logic       frame_end,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  logic [2:0] sclk_s, cs_s;
  logic [1:0] mosi_s;
  logic [6:0] rx_q, rx_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] tx_q, tx_d;
  logic       cs_act, sck_rise, sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= 3'b000;
      cs_s   <= 3'b111;
      mosi_s <= 2'b00;
    end else begin
      sclk_s <= {sclk_s[1:0], spi_sclk};
      cs_s   <= {cs_s[1:0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end
  end

  assign cs_act      = ~cs_s[1];
  assign frame_start = ~cs_s[1] & cs_s[2];
  assign frame_end   = cs_s[1] & ~cs_s[2];
  assign sck_rise    = sclk_s[1] & ~sclk_s[2];
  assign sck_fall    = ~sclk_s[1] & sclk_s[2];
  assign byte_done   = cs_act & sck_rise & (bit_q == 3'd7);
  assign rx_byte     = {rx_q, mosi_s[1]};
  assign spi_miso    = cs_act & tx_q[7];

  always_comb begin
    rx_d  = rx_q;
    bit_d = bit_q;
    tx_d  = tx_q;
    if (frame_start) begin
      bit_d = 3'd0;
      tx_d  = tx_first;
    end else if (cs_act) begin
      if (sck_rise) begin
        rx_d  = {rx_q[5:0], mosi_s[1]};
        bit_d = bit_q + 3'd1;
      end
      if (sck_fall) begin
        tx_d = (bit_q == 3'd0) ? tx_next : {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      bit_q <= '0;
      tx_q  <= '0;
    end else begin
      rx_q  <= rx_d;
      bit_q <= bit_d;
      tx_q  <= tx_d;
    end
  end
endmodule

// File: rtl/mspi_frame_ctrl.sv
module mspi_frame_ctrl
  import mspi_pkg::*;
#(
  parameter int N_MOTOR = 5,
  parameter int DUTY_W  = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_start,
  input  logic                        frame_end,
  input  logic                        byte_done,
  input  logic [7:0]                  rx_byte,
  input  logic [(N_MOTOR-1)*16-1:0]   enc_delta_flat,
  input  logic [15:0]                 delta_time,
  input  logic [N_MOTOR*8-1:0]        hall_flat,
  input  logic [N_MOTOR*DUTY_W-1:0]   duty_flat,
  output logic [7:0]                  tx_next,
  output logic                        op_valid,
  output logic [7:0]                  op_code,
  output logic                        wr_en,
  output logic [$clog2(N_MOTOR)-1:0]  wr_idx,
  output logic                        wr_hi,
  output logic                        commit
);
  localparam int PAY_LEN = 2 * N_MOTOR;
  localparam int CNT_W   = $clog2(PAY_LEN + 2) + 1;
  localparam int IDX_W   = $clog2(N_MOTOR);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [7:0]       cmd_q, cmd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, pm1;
  logic [IDX_W-1:0] widx;
  logic             in_words, in_halls;
  logic [15:0]      enc_w  [N_MOTOR];
  logic [15:0]      duty_w [N_MOTOR];

  for (genvar i = 0; i < N_MOTOR; i++) begin : g_words
    if (i < N_MOTOR - 1) begin : g_enc
      assign enc_w[i] = enc_delta_flat[i*16 +: 16];
    end else begin : g_dt
      assign enc_w[i] = delta_time;
    end
    assign duty_w[i] = {{(16-DUTY_W){1'b0}}, duty_flat[i*DUTY_W +: DUTY_W]};
  end

  always_comb begin
    cmd_d = cmd_q;
    cnt_d = cnt_q;
    if (frame_start) begin
      cmd_d = 8'h00;
      cnt_d = '0;
    end else if (byte_done) begin
      if (cnt_q == '0) cmd_d = rx_byte;
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 8'h00;
      cnt_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      cnt_q <= cnt_d;
    end
  end

  assign pm1      = cnt_q - 1'b1;
  assign widx     = pm1[IDX_W:1];
  assign in_words = (cnt_q != '0) && (cnt_q <= CNT_W'(PAY_LEN));
  assign in_halls = (cnt_q != '0) && (cnt_q <= CNT_W'(N_MOTOR));

  assign op_valid = byte_done && (cnt_q == '0);
  assign op_code  = rx_byte;
  assign wr_en    = byte_done && in_words && (cmd_q == OP_WR_DUTY);
  assign wr_idx   = widx;
  assign wr_hi    = pm1[0];
  assign commit   = frame_end && (cmd_q == OP_WR_DUTY) && (cnt_q > CNT_W'(PAY_LEN));

  always_comb begin
    tx_next = 8'h00;
    unique case (cmd_q)
      OP_WR_DUTY, OP_RD_ENC: begin
        if (in_words) tx_next = pm1[0] ? enc_w[widx][7:0] : enc_w[widx][15:8];
      end
      OP_RD_DUTY: begin
        if (in_words) tx_next = pm1[0] ? duty_w[widx][7:0] : duty_w[widx][15:8];
      end
      OP_RD_HALL: begin
        if (in_halls) tx_next = hall_flat[int'(pm1)*8 +: 8];
      end
      default: tx_next = 8'h00;
    endcase
  end
endmodule

// File: rtl/mspi_duty_bank.sv
module mspi_duty_bank #(
  parameter int N_MOTOR  = 5,
  parameter int DUTY_W   = 11,
  parameter int DUTY_MAX = 511
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(N_MOTOR)-1:0] wr_idx,
  input  logic                       wr_hi,
  input  logic [7:0]                 wr_byte,
  input  logic                       commit,
  output logic [N_MOTOR*DUTY_W-1:0]  duty_flat
);
  localparam int MAG_W = DUTY_W - 1;
  localparam logic [MAG_W-1:0] MAG_CAP = MAG_W'(DUTY_MAX);

  for (genvar i = 0; i < N_MOTOR; i++) begin : g_mot
    logic [15:0]       pend_q, pend_d;
    logic [DUTY_W-1:0] duty_q, duty_d;
    logic [MAG_W-1:0]  mag;
    logic              hit;

    assign hit = wr_en && (wr_idx == i[$clog2(N_MOTOR)-1:0]);
    assign mag = pend_q[MAG_W-1:0];

    always_comb begin
      pend_d = pend_q;
      if (hit) begin
        if (wr_hi) pend_d[15:8] = wr_byte;
        else       pend_d[7:0]  = wr_byte;
      end
      duty_d = duty_q;
      if (commit) duty_d = {pend_q[DUTY_W-1], (mag > MAG_CAP) ? MAG_CAP : mag};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= '0;
        duty_q <= '0;
      end else begin
        pend_q <= pend_d;
        duty_q <= duty_d;
      end
    end

    assign duty_flat[i*DUTY_W +: DUTY_W] = duty_q;
  end
endmodule

// File: rtl/mspi_enable_ctrl.sv
module mspi_enable_ctrl
  import mspi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  output logic       motors_en,
  output logic       wdog_kick
);
  kick_seq_e seq_q, seq_d;
  logic      en_q, en_d, kick_q, kick_d;

  always_comb begin
    seq_d  = seq_q;
    en_d   = en_q;
    kick_d = 1'b0;
    if (op_valid) begin
      unique case (op_code)
        OP_MOTOR_ON: begin
          en_d   = 1'b1;
          kick_d = (seq_q == KSEQ_ON_OFF);
          seq_d  = KSEQ_ON;
        end
        OP_MOTOR_OFF: begin
          en_d  = 1'b0;
          seq_d = (seq_q == KSEQ_ON) ? KSEQ_ON_OFF : KSEQ_IDLE;
        end
        OP_WR_DUTY: begin
          kick_d = 1'b1;
          seq_d  = KSEQ_IDLE;
        end
        OP_RD_ENC, OP_RD_HALL, OP_RD_DUTY: seq_d = KSEQ_IDLE;
        default: seq_d = seq_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= KSEQ_IDLE;
      en_q   <= 1'b0;
      kick_q <= 1'b0;
    end else begin
      seq_q  <= seq_d;
      en_q   <= en_d;
      kick_q <= kick_d;
    end
  end

  assign motors_en = en_q;
  assign wdog_kick = kick_q;
endmodule

// File: rtl/motor_spi_regs.sv
module motor_spi_regs #(
  parameter int N_MOTOR  = 5,
  parameter int DUTY_W   = 11,
  parameter int DUTY_MAX = 511
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        spi_sclk,
  input  logic                        spi_cs_n,
  input  logic                        spi_mosi,
  output logic                        spi_miso,
  input  logic                        sys_ready,
  input  logic                        wdog_tripped,
  input  logic [N_MOTOR-1:0]          motor_fault,
  input  logic [(N_MOTOR-1)*16-1:0]   enc_delta_flat,
  input  logic [15:0]                 delta_time,
  input  logic [N_MOTOR*8-1:0]        hall_flat,
  output logic [N_MOTOR*DUTY_W-1:0]   duty_flat,
  output logic                        motors_en,
  output logic                        wdog_kick
);
  localparam int IDX_W = $clog2(N_MOTOR);

  logic [7:0]       status, tx_next, rx_byte, op_code;
  logic             frame_start, frame_end, byte_done, op_valid;
  logic             wr_en, wr_hi, commit;
  logic [IDX_W-1:0] wr_idx;

  assign status = 8'({sys_ready, wdog_tripped, motors_en, motor_fault});

  mspi_shifter i_shift (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .tx_first(status), .tx_next(tx_next), .spi_miso(spi_miso),
    .frame_start(frame_start), .frame_end(frame_end),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  mspi_frame_ctrl #(.N_MOTOR(N_MOTOR), .DUTY_W(DUTY_W)) i_frame (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .frame_end(frame_end),
    .byte_done(byte_done), .rx_byte(rx_byte),
    .enc_delta_flat(enc_delta_flat), .delta_time(delta_time),
    .hall_flat(hall_flat), .duty_flat(duty_flat),
    .tx_next(tx_next), .op_valid(op_valid), .op_code(op_code),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi), .commit(commit)
  );

  mspi_duty_bank #(.N_MOTOR(N_MOTOR), .DUTY_W(DUTY_W), .DUTY_MAX(DUTY_MAX)) i_duty (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_byte(rx_byte),
    .commit(commit), .duty_flat(duty_flat)
  );

  mspi_enable_ctrl i_en (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_code(op_code),
    .motors_en(motors_en), .wdog_kick(wdog_kick)
  );
endmodule

// File: rtl/motor_spi_regs_chk.sv
module motor_spi_regs_chk #(
  parameter int N_MOTOR  = 5,
  parameter int DUTY_W   = 11,
  parameter int DUTY_MAX = 511
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      spi_cs_n,
  input logic                      spi_miso,
  input logic                      motors_en,
  input logic                      wdog_kick,
  input logic [N_MOTOR*DUTY_W-1:0] duty_flat
);
  assert_kick_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_kick |=> !wdog_kick);

  assert_kick_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_kick |-> !$past(spi_cs_n));

  assert_duty_on_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_flat) |-> $past(spi_cs_n));

  assert_enable_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(motors_en) |-> !$past(spi_cs_n));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso);

  for (genvar i = 0; i < N_MOTOR; i++) begin : g_mag
    always @(posedge clk) begin
      if (rst_n) begin
        assert_mag_limit_R4: assert (duty_flat[i*DUTY_W +: DUTY_W-1] <= (DUTY_W-1)'(DUTY_MAX));
      end
    end
  end
endmodule

bind motor_spi_regs motor_spi_regs_chk #(
  .N_MOTOR(N_MOTOR), .DUTY_W(DUTY_W), .DUTY_MAX(DUTY_MAX)
) i_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .motors_en(motors_en), .wdog_kick(wdog_kick), .duty_flat(duty_flat)
);

// File: tb/test_motor_spi_regs.sv
`timescale 1ns/1ps
module test_motor_spi_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso;
  logic        sys_ready = 1'b0, wdog_tripped = 1'b0;
  logic [4:0]  motor_fault = '0;
  logic [63:0] enc_delta_flat = '0;
  logic [15:0] delta_time = '0;
  logic [39:0] hall_flat = '0;
  logic [54:0] duty_flat;
  logic        motors_en, wdog_kick;

  int checks = 0, errors = 0, kicks = 0;
  logic [7:0]  mo [16];
  logic [7:0]  mi [16];
  logic [10:0] exp_duty [5];

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n && wdog_kick) kicks++;

  motor_spi_regs i_motor_spi_regs (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .sys_ready(sys_ready),
    .wdog_tripped(wdog_tripped), .motor_fault(motor_fault),
    .enc_delta_flat(enc_delta_flat), .delta_time(delta_time),
    .hall_flat(hall_flat), .duty_flat(duty_flat),
    .motors_en(motors_en), .wdog_kick(wdog_kick)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input int n);
    spi_cs_n = 1'b0;
    #100;
    for (int b = 0; b < n; b++) begin
      for (int k = 7; k >= 0; k--) begin
        spi_mosi = mo[b][k];
        #80;
        mi[b][k] = spi_miso;
        spi_sclk = 1'b1;
        #80;
        spi_sclk = 1'b0;
      end
    end
    #80;
    spi_cs_n = 1'b1;
    #40;
  endtask

  function automatic logic [10:0] sat(input logic [15:0] w);
    logic [9:0] m;
    m = (w[9:0] > 10'd511) ? 10'd511 : w[9:0];
    return {w[10], m};
  endfunction

  function automatic logic [15:0] enc_word(input int i);
    return (i < 4) ? enc_delta_flat[i*16 +: 16] : delta_time;
  endfunction

  task automatic check_duties(input string req);
    for (int m = 0; m < 5; m++) chk(req, 64'(duty_flat[m*11 +: 11]), 64'(exp_duty[m]));
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] raw [5];
    int k0;
    for (int m = 0; m < 5; m++) exp_duty[m] = '0;
    #2;
    #50 rst_n = 1'b1;
    #50;
    chk("R2 reset enable", 64'(motors_en), 0);
    chk("R3 reset duties", 64'(duty_flat), 0);
    chk("R12 reset miso", 64'(spi_miso), 0);
    chk("R10 reset kick", 64'(kicks), 0);

    // enable from idle: no kick
    mo[0] = 8'hB0; xfer(1);
    chk("R2 enable set", 64'(motors_en), 1);
    chk("R11 lone enable no kick", 64'(kicks), 0);

    // unknown-command sweep over status inputs
    for (int i = 0; i < 32; i++) begin
      motor_fault = 5'(i);
      sys_ready = i[0]; wdog_tripped = i[2];
      mo[0] = 8'(i * 37 + 1);
      if (mo[0] == 8'h30 || mo[0] == 8'hB0 || mo[0] == 8'h80 || mo[0][7:2] == 6'b100100)
        mo[0] = 8'h01;
      for (int b = 1; b < 4; b++) mo[b] = 8'hA5;
      xfer(4);
      chk("R1 status byte", 64'(mi[0]), 64'({i[0], i[2], 1'b1, 5'(i)}));
      for (int b = 1; b < 4; b++) chk("R9 unknown zeros", 64'(mi[b]), 0);
      chk("R9 enable kept", 64'(motors_en), 1);
      chk("R9 duties kept", 64'(duty_flat), 0);
      chk("R12 idle miso", 64'(spi_miso), 0);
    end
    sys_ready = 1'b1; wdog_tripped = 1'b0; motor_fault = 5'b00000;

    // duty write sweep with back-to-back readback
    for (int k = 0; k < 12; k++) begin
      enc_delta_flat = {16'(k*911 + 3), 16'(16'hFFFE - k), 16'(16'h7F01 + k*3), 16'(16'h8123 ^ k)};
      delta_time = 16'(16'h1234 + k*77);
      for (int m = 0; m < 5; m++) raw[m] = 16'(k*4099 + m*12345 + 7);
      if (k == 1) begin
        raw[0] = 16'h01FF; raw[1] = 16'h0200; raw[2] = 16'h05FF; raw[3] = 16'hFE00; raw[4] = 16'h03FF;
      end
      mo[0] = 8'h80;
      for (int m = 0; m < 5; m++) begin
        mo[1 + 2*m] = raw[m][7:0];
        mo[2 + 2*m] = raw[m][15:8];
        exp_duty[m] = sat(raw[m]);
      end
      k0 = kicks;
      xfer(11);
      chk("R1 status in write", 64'(mi[0]), 64'(8'hA0));
      for (int w = 0; w < 5; w++) begin
        chk("R5 enc word hi", 64'(mi[1 + 2*w]), 64'(enc_word(w)[15:8]));
        chk("R5 enc word lo", 64'(mi[2 + 2*w]), 64'(enc_word(w)[7:0]));
      end
      check_duties("R3 R4 committed duty");
      chk("R10 write kicks once", 64'(kicks - k0), 1);
      mo[0] = 8'h93;
      for (int b = 1; b < 11; b++) mo[b] = 8'h00;
      xfer(11);
      for (int m = 0; m < 5; m++) begin
        chk("R7 duty hi", 64'(mi[1 + 2*m]), 64'({5'b0, exp_duty[m][10:8]}));
        chk("R7 duty lo", 64'(mi[2 + 2*m]), 64'(exp_duty[m][7:0]));
      end
    end

    // encoder-only read
    mo[0] = 8'h91; xfer(13);
    for (int w = 0; w < 5; w++) begin
      chk("R5 read enc hi", 64'(mi[1 + 2*w]), 64'(enc_word(w)[15:8]));
      chk("R5 read enc lo", 64'(mi[2 + 2*w]), 64'(enc_word(w)[7:0]));
    end
    chk("R8 tail zero", 64'(mi[11]), 0);
    chk("R8 tail zero", 64'(mi[12]), 0);

    // truncated write frame
    k0 = kicks;
    mo[0] = 8'h80;
    for (int b = 1; b < 6; b++) mo[b] = 8'h11;
    xfer(6);
    check_duties("R3 partial frame ignored");
    chk("R10 partial kick", 64'(kicks - k0), 1);

    // write with trailing bytes
    mo[0] = 8'h80;
    for (int m = 0; m < 5; m++) begin
      mo[1 + 2*m] = 8'(m * 50 + 9);
      mo[2 + 2*m] = (m[0]) ? 8'h04 : 8'h01;
      exp_duty[m] = sat({mo[2 + 2*m], mo[1 + 2*m]});
    end
    for (int b = 11; b < 15; b++) mo[b] = 8'hFF;
    xfer(15);
    for (int b = 11; b < 15; b++) chk("R8 tail zero", 64'(mi[b]), 0);
    check_duties("R8 tail bytes ignored");

    // hall read
    hall_flat = 40'h05_34_21_63_16;
    mo[0] = 8'h92; for (int b = 1; b < 8; b++) mo[b] = 8'h00;
    xfer(8);
    for (int h = 0; h < 5; h++) chk("R6 hall", 64'(mi[1 + h]), 64'(hall_flat[h*8 +: 8]));
    chk("R8 hall tail", 64'(mi[6]), 0);
    chk("R8 hall tail", 64'(mi[7]), 0);

    // enable/disable refresh sequence
    k0 = kicks;
    mo[0] = 8'hB0; xfer(1);
    mo[0] = 8'h30; xfer(1);
    chk("R2 disable clears", 64'(motors_en), 0);
    mo[0] = 8'h55; xfer(1);
    mo[0] = 8'hB0; xfer(1);
    chk("R11 on-off-on kicks", 64'(kicks - k0), 1);
    k0 = kicks;
    mo[0] = 8'h30; xfer(1);
    mo[0] = 8'h92; xfer(1);
    mo[0] = 8'hB0; xfer(1);
    chk("R11 broken sequence no kick", 64'(kicks - k0), 0);
    chk("R2 enable again", 64'(motors_en), 1);
    mo[0] = 8'h30; xfer(1);
    chk("R2 final disable", 64'(motors_en), 0);
    chk("R12 final idle", 64'(spi_miso), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule